// File: doc/BRIEF.md
# Oversampled Phase-Frequency Detector with Selectable Antibacklash Hold

This block compares the rising edges of a reference clock and a divided feedback clock. Both are sampled in a fast system clock domain. It produces pump-up and pump-down request pulses for a charge pump. A reference edge raises the up request and a feedback edge raises the down request. When both requests are high, they stay high together for an antibacklash hold. After the hold, both drop in the same cycle. This overlap removes the dead zone around zero phase error. The lead request is therefore longer than the lag request by the edge offset, so the outputs carry both phase and frequency error.

One control input picks the hold length. A low value selects the long hold, which suits fractional division. A high value selects the short hold, which suits integer division. Both lengths are parameters counted in system-clock cycles. The long hold must exceed the short one, and the short hold must be at least one cycle.

A lock monitor checks each comparison, meaning each joint clear of the two requests. It measures the number of cycles in which exactly one request was high. It raises a lock flag after a run of consecutive comparisons whose width stays below a threshold.

Top module: `phase_freq_det`

## Requirements
- R1: Each input passes through a two-flop synchronizer and a rising-edge detector. The first system-clock edge samples the input high. `up` (from `ref_in`) or `dn` (from `fb_in`) goes high on the second edge after that one.
- R2: `up` and `dn` never clear on their own. A flag clears only in the cycle that ends an interval in which both flags were high, and both clear together.
- R3: When `narrow_sel` = 0, both flags stay high together for WIDE_CYC cycles before they clear. When `narrow_sel` = 1, they stay high together for NARROW_CYC cycles. The value of `narrow_sel` is taken in the first cycle of the overlap.
- R4: Suppose the lagging input rises d cycles after the leading one. Then the leading flag stays high for d plus the hold, and the lagging flag stays high for the hold. With d = 0, both flags pulse for the hold (no dead zone).
- R5: A new rising edge on an input whose flag is already high, outside the clearing cycle, has no effect on that flag's pulse.
- R6: If a new rising edge would set a flag in the same cycle as the antibacklash clear, the set wins. That flag stays high and starts a new comparison.
- R7: A comparison counts as good when the number of cycles with exactly one flag high, since the previous comparison, is below WIDTH_THR. `locked` rises in the clearing cycle that completes LOCK_RUNS consecutive good comparisons.
- R8: A comparison whose single-flag width is WIDTH_THR or more drops `locked` and restarts the run of good comparisons.
- R9: During reset and right after it, `up`, `dn` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| fb_in | input | 1 | Divided feedback clock, asynchronous to clk |
| narrow_sel | input | 1 | Hold select: 0 long, 1 short |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| locked | output | 1 | Lock indication |

## Verification
The antibacklash clear and a fresh input edge can land in the same cycle. When they do, the set must win. The bench provokes this by placing a second reference pulse so that its detected edge lands exactly on the clearing cycle of the first comparison. A later feedback pulse then completes a second comparison. The bench judges the result from the total high time of `up` and `dn`. The clear must not have swallowed the new edge, which would give a short `up` and a lost comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic {
        ABL_WIDE   = 1'b0,
        ABL_NARROW = 1'b1
    } abl_sel_e;

    typedef struct packed {
        logic fb_rise;
        logic ref_rise;
    } edge_pair_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    function automatic int unsigned abl_hold(input abl_sel_e sel,
                                             input int unsigned wide_cyc,
                                             input int unsigned narrow_cyc);
        return (sel == ABL_NARROW) ? narrow_cyc : wide_cyc;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int unsigned N_CH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] rise
);

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= raw[ch];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise[ch] = sync_q & ~prev_q;
    end

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
    import pfd_pkg::*;
#(
    parameter int unsigned WIDE_CYC   = 4,
    parameter int unsigned NARROW_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges,
    input  abl_sel_e   sel,
    output pump_req_t  flags,
    output logic       cmp_done
);

    localparam int unsigned CNT_W = $clog2(WIDE_CYC + 1);

    pump_req_t        flags_q;
    logic [CNT_W-1:0] ovl_cnt;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] hold_now;
    logic             both;
    logic             clr;

    assign both     = flags_q.up & flags_q.dn;
    // hold length is frozen in the first overlap cycle
    assign hold_now = (ovl_cnt == '0) ? CNT_W'(abl_hold(sel, WIDE_CYC, NARROW_CYC))
                                      : hold_q;
    assign clr      = both && (ovl_cnt == hold_now - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ovl_cnt <= '0;
            hold_q  <= '0;
        end else begin
            if (both && ovl_cnt == '0)
                hold_q <= hold_now;
            if (both && !clr)
                ovl_cnt <= ovl_cnt + 1'b1;
            else
                ovl_cnt <= '0;
            // a set arriving in the clearing cycle wins
            flags_q.up <= (flags_q.up & ~clr) | edges.ref_rise;
            flags_q.dn <= (flags_q.dn & ~clr) | edges.fb_rise;
        end
    end

    assign flags    = flags_q;
    assign cmp_done = clr;

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_THR = 3,
    parameter int unsigned LOCK_RUNS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  pump_req_t flags,
    input  logic      cmp_done,
    output logic      locked
);

    localparam int unsigned W_W = $clog2(WIDTH_THR + 1);
    localparam int unsigned R_W = $clog2(LOCK_RUNS + 1);

    logic [W_W-1:0] width_q;
    logic [R_W-1:0] run_q;
    logic           locked_q;
    logic           single;
    logic           good;

    assign single = flags.up ^ flags.dn;
    assign good   = (width_q < W_W'(WIDTH_THR));

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q  <= '0;
            run_q    <= '0;
            locked_q <= 1'b0;
        end else if (cmp_done) begin
            width_q <= '0;
            if (good) begin
                if (run_q != R_W'(LOCK_RUNS))
                    run_q <= run_q + 1'b1;
                locked_q <= (run_q >= R_W'(LOCK_RUNS - 1));
            end else begin
                run_q    <= '0;
                locked_q <= 1'b0;
            end
        end else if (single && width_q != W_W'(WIDTH_THR)) begin
            width_q <= width_q + 1'b1;
        end
    end

    assign locked = locked_q;

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det
    import pfd_pkg::*;
#(
    parameter int unsigned WIDE_CYC   = 4,
    parameter int unsigned NARROW_CYC = 2,
    parameter int unsigned WIDTH_THR  = 3,
    parameter int unsigned LOCK_RUNS  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    input  logic narrow_sel,
    output logic up,
    output logic dn,
    output logic locked
);

    logic [1:0] rise_vec;
    edge_pair_t edges;
    pump_req_t  flags;
    logic       cmp_done;

    pfd_edge_sync #(.N_CH(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({fb_in, ref_in}),
        .rise (rise_vec)
    );

    assign edges.ref_rise = rise_vec[0];
    assign edges.fb_rise  = rise_vec[1];

    pfd_flag_core #(
        .WIDE_CYC   (WIDE_CYC),
        .NARROW_CYC (NARROW_CYC)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .edges    (edges),
        .sel      (abl_sel_e'(narrow_sel)),
        .flags    (flags),
        .cmp_done (cmp_done)
    );

    pfd_lock_mon #(
        .WIDTH_THR (WIDTH_THR),
        .LOCK_RUNS (LOCK_RUNS)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .flags    (flags),
        .cmp_done (cmp_done),
        .locked   (locked)
    );

    assign up = flags.up;
    assign dn = flags.dn;

endmodule

// File: rtl/phase_freq_det_chk.sv
module phase_freq_det_chk #(
    parameter int unsigned WIDE_CYC   = 4,
    parameter int unsigned NARROW_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic ref_in,
    input logic fb_in,
    input logic up,
    input logic dn,
    input logic locked
);

    localparam int unsigned RUN_W = $clog2(WIDE_CYC + 2) + 1;

    logic [RUN_W-1:0] run;
    logic [1:0]       age;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
            age <= '0;
        end else begin
            if (up && dn) begin
                if (run != '1)
                    run <= run + 1'b1;
            end else begin
                run <= '0;
            end
            if (age != 2'd3)
                age <= age + 1'b1;
        end
    end

    assert_dn_clear_joint_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(dn) |-> $past(up));

    assert_up_clear_joint_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(up) |-> $past(dn));

    assert_overlap_min_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(up && dn) && !(up && dn)) |-> (run >= RUN_W'(NARROW_CYC)));

    assert_up_from_ref_R1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $rose(up)) |-> $past(ref_in, 3));

    assert_dn_from_fb_R1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $rose(dn)) |-> $past(fb_in, 3));

    assert_lock_on_compare_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(up && dn));

endmodule

bind phase_freq_det phase_freq_det_chk #(
    .WIDE_CYC   (WIDE_CYC),
    .NARROW_CYC (NARROW_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .up     (up),
    .dn     (dn),
    .locked (locked)
);

// File: tb/tb_phase_freq_det.sv
module tb_phase_freq_det;

    localparam int WIDE   = 4;
    localparam int NARROW = 2;
    localparam int THR    = 3;
    localparam int RUNS   = 3;
    localparam int WIN    = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic narrow_sel = 1'b0;
    logic up, dn, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phase_freq_det #(
        .WIDE_CYC (WIDE), .NARROW_CYC (NARROW),
        .WIDTH_THR (THR), .LOCK_RUNS (RUNS)
    ) dut (
        .clk (clk), .rst (rst), .ref_in (ref_in), .fb_in (fb_in),
        .narrow_sel (narrow_sel), .up (up), .dn (dn), .locked (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [WIN-1:0] pulse(input int a, input int b);
        logic [WIN-1:0] v = '0;
        for (int i = a; i < b; i++) v[i] = 1'b1;
        return v;
    endfunction

    // drives one input bit per negedge; counts high cycles and first index
    task automatic run_pat(input logic [WIN-1:0] rp, input logic [WIN-1:0] fp,
                           output int nu, output int nd,
                           output int fu, output int fd);
        nu = 0; nd = 0; fu = -1; fd = -1;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            ref_in = rp[i];
            fb_in  = fp[i];
            if (up) begin nu++; if (fu < 0) fu = i; end
            if (dn) begin nd++; if (fd < 0) fd = i; end
        end
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic shot(input int d, input bit fb_lead,
                        output int nu, output int nd, output int fu, output int fd);
        logic [WIN-1:0] lead = pulse(0, 3);
        logic [WIN-1:0] lag  = pulse(d, d + 3);
        if (fb_lead) run_pat(lag, lead, nu, nd, fu, fd);
        else         run_pat(lead, lag, nu, nd, fu, fd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nu, nd, fu, fd, h;
        repeat (3) @(negedge clk);
        check("R9 up in reset", int'(up), 0);
        check("R9 dn in reset", int'(dn), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 up after reset", int'(up), 0);
        check("R9 dn after reset", int'(dn), 0);
        check("R9 locked after reset", int'(locked), 0);

        // R1 R3 R4 sweep: both holds, both lead orders, offsets 0..6
        for (int s = 0; s < 2; s++) begin
            narrow_sel = s[0];
            h = s ? NARROW : WIDE;
            for (int o = 0; o < 2; o++) begin
                for (int d = 0; d < 7; d++) begin
                    shot(d, o[0], nu, nd, fu, fd);
                    if (o == 0) begin
                        check("R4 lead up width", nu, d + h);
                        check("R3 lag dn width", nd, h);
                        check("R1 up first cycle", fu, 3);
                        check("R1 dn first cycle", fd, d + 3);
                    end else begin
                        check("R4 lead dn width", nd, d + h);
                        check("R3 lag up width", nu, h);
                        check("R1 dn first cycle", fd, 3);
                        check("R1 up first cycle", fu, d + 3);
                    end
                end
            end
        end

        // R5: second reference edge while up is already high
        narrow_sel = 1'b0;
        run_pat(pulse(0, 2) | pulse(4, 6), pulse(8, 11), nu, nd, fu, fd);
        check("R5 up width with extra ref edge", nu, 8 + WIDE);
        check("R5 dn width with extra ref edge", nd, WIDE);

        // R6: second reference edge lands on the clearing cycle (d=3, hold 4)
        run_pat(pulse(0, 2) | pulse(7, 9), pulse(3, 5) | pulse(12, 14), nu, nd, fu, fd);
        check("R6 up held through clear", nu, 12 + WIDE);
        check("R6 dn two comparisons", nd, 2 * WIDE);
        check("R2 up low after joint clears", int'(up), 0);
        check("R2 dn low after joint clears", int'(dn), 0);

        // R7 R8: lock monitor, short hold
        narrow_sel = 1'b1;
        shot(5, 1'b0, nu, nd, fu, fd);
        check("R8 wide comparison unlocks", int'(locked), 0);
        shot(1, 1'b0, nu, nd, fu, fd);
        check("R7 one good comparison", int'(locked), 0);
        shot(1, 1'b1, nu, nd, fu, fd);
        check("R7 two good comparisons", int'(locked), 0);
        shot(1, 1'b0, nu, nd, fu, fd);
        check("R7 three good comparisons lock", int'(locked), 1);
        shot(THR - 1, 1'b0, nu, nd, fu, fd);
        check("R7 width just below threshold keeps lock", int'(locked), 1);
        shot(THR, 1'b1, nu, nd, fu, fd);
        check("R8 width at threshold unlocks", int'(locked), 0);
        for (int k = 0; k < RUNS; k++) begin
            shot(0, 1'b0, nu, nd, fu, fd);
            check("R7 zero-offset run", int'(locked), (k == RUNS - 1) ? 1 : 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule